// File: doc/BRIEF.md
# Thread Block Residency Calculator

This unit answers one question for a kernel launch: how many thread blocks of a given shape fit at the same time on one streaming multiprocessor. Software or a dispatch front end gives it a launch shape. The shape is the threads in each block, the registers each thread needs and the scratchpad bytes each block needs. The unit then reports the number of resident blocks, the fraction of the thread slots those blocks fill, and how much register file and scratchpad stays unused because capacity is only handed out in whole blocks.

The unit derives four separate ceilings on the block count:

- the register file divided by the registers one block needs;
- the scratchpad divided by the bytes one block needs;
- the thread slots divided by the threads in one block;
- a fixed cap on the number of blocks.

Each ceiling is an integer quotient rounded down, and the smallest one wins. A single restoring divider works out all the quotients one after another, one quotient bit per clock. This keeps the area small at the cost of a few dozen cycles for each query. A request is a one-cycle `start` pulse. The answer is valid in the cycle where `done` pulses, and it stays on the outputs until the next answer.

Top module: `residency_calc`

## Requirements
- R1: The register ceiling is floor(REG_CAP / (regs_per_thr × thr_per_blk)). When this ceiling is the smallest of the four, it sets `blocks_o`. It is 0 when one block needs more registers than REG_CAP.
- R2: The scratchpad ceiling is floor(SPAD_CAP / spad_per_blk). A value of 0 for `spad_per_blk_i` means the block makes no scratchpad demand, so this ceiling does not limit the result.
- R3: The thread ceiling is floor(THR_MAX / thr_per_blk).
- R4: `blocks_o` is the minimum of the register, scratchpad and thread ceilings and BLK_MAX, so it never exceeds BLK_MAX.
- R5: `occ_o` equals floor(blocks_o × thr_per_blk × 65536 / THR_MAX). The value 65536 (every thread slot filled) saturates to 65535, and `occ_o` is 0 whenever `blocks_o` is 0.
- R6: `reg_left_o` equals REG_CAP − blocks_o × regs_per_thr × thr_per_blk.
- R7: `spad_left_o` equals SPAD_CAP − blocks_o × spad_per_blk.
- R8: If `thr_per_blk_i` or `regs_per_thr_i` is 0, then `err_o` is 1 and `blocks_o`, `occ_o`, `reg_left_o` and `spad_left_o` are all 0. Otherwise `err_o` is 0.
- R9: `busy_o` rises in the cycle after an accepted `start_i` and stays high up to and including the cycle of `done_o`. `done_o` is high for exactly one cycle. The result outputs change only in a cycle in which `done_o` is high.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. It changes neither the result being computed nor the number of `done_o` pulses.
- R11: After reset, `busy_o`, `done_o`, `err_o` and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request; accepted only while idle |
| thr_per_blk_i | input | TPB_W | Threads in each block |
| regs_per_thr_i | input | RPT_W | Registers each thread needs |
| spad_per_blk_i | input | SPB_W | Scratchpad bytes each block needs; 0 means none |
| busy_o | output | 1 | A query is in progress |
| done_o | output | 1 | One-cycle pulse; the results are valid |
| err_o | output | 1 | Zero thread count or zero register count was given |
| blocks_o | output | clog2(BLK_MAX+1) | Resident blocks |
| occ_o | output | 16 | Occupancy as a fraction of 65536 |
| reg_left_o | output | clog2(REG_CAP+1) | Registers left unused |
| spad_left_o | output | clog2(SPAD_CAP+1) | Scratchpad bytes left unused |

## Verification
The main instance in the bench is built small: 256 registers, 24 scratchpad bytes, 4 blocks, 48 threads, and narrow input fields. With this configuration, a sweep over thread counts 0 to 15, register counts 0 to 5 and scratchpad sizes 0 to 9 lets each of the four ceilings be the one that decides the result, in many combinations. The sweep also covers the zero-input error cases and exact full occupancy with its saturation. Directed cases push the register need and the scratchpad need above capacity. A second instance with the full-size default parameters runs a few large launch shapes whose answers are known by hand. The ignored-start behaviour is checked by sending a different request while a query is in progress.

// File: rtl/residency_pkg.sv
package residency_pkg;

    localparam int OCC_W = 16;

    typedef enum logic [1:0] {
        OP_REG  = 2'd0,
        OP_SPAD = 2'd1,
        OP_THR  = 2'd2,
        OP_OCC  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_DONE   = 2'd3
    } state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rc_divider.sv
module rc_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  shq_q;
    logic [W-1:0]  part_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] left_q;
    logic          busy_q;
    logic          done_q;

    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          fits;
    logic [W-1:0]  part_nx;
    logic [W-1:0]  shq_nx;

    // restoring step: bring in the next numerator bit, subtract when it fits
    always_comb begin
        trial   = {part_q, shq_q[W-1]};
        diff    = trial - {1'b0, dvs_q};
        fits    = (trial >= {1'b0, dvs_q});
        part_nx = fits ? diff[W-1:0] : trial[W-1:0];
        shq_nx  = {shq_q[W-2:0], fits};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shq_q  <= '0;
            part_q <= '0;
            dvs_q  <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go && !busy_q) begin
                shq_q  <= num;
                part_q <= '0;
                dvs_q  <= den;
                left_q <= CW'(W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                shq_q  <= shq_nx;
                part_q <= part_nx;
                left_q <= left_q - CW'(1);
                if (left_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quo  = shq_q;

    // partial remainder always stays below the divisor (quotient digit in range)
    p_part_below_dvs_r1: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (part_q < dvs_q));

    // the sequencer never asks for a division by zero
    p_den_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (go && !busy_q) |-> (den != '0));

endmodule

// File: rtl/rc_min4.sv
module rc_min4 #(
    parameter int W = 4
) (
    input  logic [3:0][W-1:0] vals,
    output logic [W-1:0]      least
);
    always_comb begin
        least = vals[0];
        for (int i = 1; i < 4; i++) begin
            if (vals[i] < least) least = vals[i];
        end
    end
endmodule

// File: rtl/rc_leftover.sv
module rc_leftover #(
    parameter int CAP = 256,
    parameter int CW  = 9,
    parameter int NW  = 3,
    parameter int UW  = 8
) (
    input  logic [NW-1:0] count,
    input  logic [UW-1:0] unit,
    output logic [CW-1:0] left
);
    localparam int PW = NW + UW;
    localparam int XW = (PW > CW) ? PW : CW;

    logic [PW-1:0] used;
    logic [XW-1:0] wide;

    always_comb begin
        used = PW'(count) * PW'(unit);
        wide = XW'(CAP) - XW'(used);
        left = wide[CW-1:0];
    end
endmodule

// File: rtl/residency_calc.sv
module residency_calc
    import residency_pkg::*;
#(
    parameter int REG_CAP  = 32768,
    parameter int SPAD_CAP = 16384,
    parameter int BLK_MAX  = 8,
    parameter int THR_MAX  = 1536,
    parameter int TPB_W    = 11,
    parameter int RPT_W    = 8,
    parameter int SPB_W    = 15,
    localparam int BLK_W   = $clog2(BLK_MAX + 1),
    localparam int REG_W   = $clog2(REG_CAP + 1),
    localparam int SPAD_W  = $clog2(SPAD_CAP + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [TPB_W-1:0]  thr_per_blk_i,
    input  logic [RPT_W-1:0]  regs_per_thr_i,
    input  logic [SPB_W-1:0]  spad_per_blk_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [BLK_W-1:0]  blocks_o,
    output logic [OCC_W-1:0]  occ_o,
    output logic [REG_W-1:0]  reg_left_o,
    output logic [SPAD_W-1:0] spad_left_o
);
    localparam int RPB_W  = RPT_W + TPB_W;
    localparam int THR_W  = $clog2(THR_MAX + 1);
    localparam int PT_W   = BLK_W + TPB_W;
    localparam int NOCC_W = PT_W + OCC_W;
    localparam int DIV_W  = max2(max2(NOCC_W, REG_W),
                                 max2(max2(RPB_W, SPAD_W), max2(SPB_W, THR_W)));

    typedef struct packed {
        logic              err;
        logic [BLK_W-1:0]  blocks;
        logic [OCC_W-1:0]  occ;
        logic [REG_W-1:0]  reg_left;
        logic [SPAD_W-1:0] spad_left;
    } result_t;

    typedef struct packed {
        logic [TPB_W-1:0] thr;
        logic [RPT_W-1:0] rpt;
        logic [SPB_W-1:0] spb;
    } shape_t;

    state_e  state_q;
    op_e     op_q;
    shape_t  shape_q;
    result_t res_q;

    logic [BLK_W-1:0] cap_reg_q;
    logic [BLK_W-1:0] cap_spad_q;
    logic [BLK_W-1:0] cap_thr_q;

    logic [RPB_W-1:0] regs_blk;
    logic [BLK_W-1:0] blocks_min;
    logic [PT_W-1:0]  res_threads;
    logic [REG_W-1:0] reg_left_w;
    logic [SPAD_W-1:0] spad_left_w;
    logic [OCC_W-1:0] occ_sat;

    logic             div_go;
    logic [DIV_W-1:0] div_num;
    logic [DIV_W-1:0] div_den;
    logic             div_busy;
    logic             div_done;
    logic [DIV_W-1:0] div_quo;
    logic             skip_spad;

    function automatic logic [BLK_W-1:0] clamp_blk(input logic [DIV_W-1:0] q);
        return (q > DIV_W'(BLK_MAX)) ? BLK_W'(BLK_MAX) : q[BLK_W-1:0];
    endfunction

    // ---------------- derived quantities ----------------
    assign regs_blk    = RPB_W'(shape_q.thr) * RPB_W'(shape_q.rpt);
    assign res_threads = PT_W'(blocks_min) * PT_W'(shape_q.thr);
    assign skip_spad   = (op_q == OP_SPAD) && (shape_q.spb == '0);

    rc_min4 #(.W(BLK_W)) u_min (
        .vals  ({BLK_W'(BLK_MAX), cap_thr_q, cap_spad_q, cap_reg_q}),
        .least (blocks_min)
    );

    rc_leftover #(.CAP(REG_CAP), .CW(REG_W), .NW(BLK_W), .UW(RPB_W)) u_reg_left (
        .count (blocks_min),
        .unit  (regs_blk),
        .left  (reg_left_w)
    );

    rc_leftover #(.CAP(SPAD_CAP), .CW(SPAD_W), .NW(BLK_W), .UW(SPB_W)) u_spad_left (
        .count (blocks_min),
        .unit  (shape_q.spb),
        .left  (spad_left_w)
    );

    // ---------------- divider operand selection ----------------
    always_comb begin
        unique case (op_q)
            OP_REG: begin
                div_num = DIV_W'(REG_CAP);
                div_den = DIV_W'(regs_blk);
            end
            OP_SPAD: begin
                div_num = DIV_W'(SPAD_CAP);
                div_den = DIV_W'(shape_q.spb);
            end
            OP_THR: begin
                div_num = DIV_W'(THR_MAX);
                div_den = DIV_W'(shape_q.thr);
            end
            default: begin
                div_num = DIV_W'({res_threads, {OCC_W{1'b0}}});
                div_den = DIV_W'(THR_MAX);
            end
        endcase
    end

    assign div_go  = (state_q == ST_LAUNCH) && !skip_spad;
    assign occ_sat = (|div_quo[DIV_W-1:OCC_W]) ? {OCC_W{1'b1}} : div_quo[OCC_W-1:0];

    rc_divider #(.W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .busy (div_busy),
        .done (div_done),
        .quo  (div_quo)
    );

    // ---------------- sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            op_q       <= OP_REG;
            shape_q    <= '0;
            res_q      <= '0;
            cap_reg_q  <= '0;
            cap_spad_q <= '0;
            cap_thr_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        shape_q.thr <= thr_per_blk_i;
                        shape_q.rpt <= regs_per_thr_i;
                        shape_q.spb <= spad_per_blk_i;
                        if (thr_per_blk_i == '0 || regs_per_thr_i == '0) begin
                            res_q     <= '0;
                            res_q.err <= 1'b1;
                            state_q   <= ST_DONE;
                        end else begin
                            op_q    <= OP_REG;
                            state_q <= ST_LAUNCH;
                        end
                    end
                end
                ST_LAUNCH: begin
                    if (skip_spad) begin
                        cap_spad_q <= BLK_W'(BLK_MAX);
                        op_q       <= OP_THR;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (div_done) begin
                        unique case (op_q)
                            OP_REG: begin
                                cap_reg_q <= clamp_blk(div_quo);
                                op_q      <= OP_SPAD;
                                state_q   <= ST_LAUNCH;
                            end
                            OP_SPAD: begin
                                cap_spad_q <= clamp_blk(div_quo);
                                op_q       <= OP_THR;
                                state_q    <= ST_LAUNCH;
                            end
                            OP_THR: begin
                                cap_thr_q <= clamp_blk(div_quo);
                                op_q      <= OP_OCC;
                                state_q   <= ST_LAUNCH;
                            end
                            default: begin
                                res_q.err       <= 1'b0;
                                res_q.blocks    <= blocks_min;
                                res_q.occ       <= occ_sat;
                                res_q.reg_left  <= reg_left_w;
                                res_q.spad_left <= spad_left_w;
                                state_q         <= ST_DONE;
                            end
                        endcase
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_DONE);
    assign err_o       = res_q.err;
    assign blocks_o    = res_q.blocks;
    assign occ_o       = res_q.occ;
    assign reg_left_o  = res_q.reg_left;
    assign spad_left_o = res_q.spad_left;

    // ---------------- assertions ----------------
    p_blocks_capped_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (blocks_o <= BLK_W'(BLK_MAX)));

    p_occ_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (done_o && blocks_o == '0) |-> (occ_o == '0));

    p_err_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (done_o && err_o) |-> (blocks_o == '0 && occ_o == '0 &&
                               reg_left_o == '0 && spad_left_o == '0));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    p_results_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable({err_o, blocks_o, occ_o, reg_left_o, spad_left_o}));

    p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> $stable(shape_q));

    p_div_idle_on_launch_r9: assert property (@(posedge clk) disable iff (rst)
        div_go |-> !div_busy);

endmodule

// File: tb/residency_calc_test.sv
module residency_calc_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    // small configuration for the sweep
    localparam int S_REG  = 256;
    localparam int S_SPAD = 24;
    localparam int S_BLK  = 4;
    localparam int S_THR  = 48;
    localparam int S_TPBW = 5;
    localparam int S_RPTW = 4;
    localparam int S_SPBW = 7;
    localparam int S_BW   = $clog2(S_BLK + 1);
    localparam int S_RW   = $clog2(S_REG + 1);
    localparam int S_SW   = $clog2(S_SPAD + 1);

    // full-size configuration
    localparam int F_REG  = 32768;
    localparam int F_SPAD = 16384;
    localparam int F_BLK  = 8;
    localparam int F_THR  = 1536;
    localparam int F_BW   = $clog2(F_BLK + 1);
    localparam int F_RW   = $clog2(F_REG + 1);
    localparam int F_SW   = $clog2(F_SPAD + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic              s_start = 1'b0;
    logic [S_TPBW-1:0] s_thr = '0;
    logic [S_RPTW-1:0] s_rpt = '0;
    logic [S_SPBW-1:0] s_spb = '0;
    logic              s_busy, s_done, s_err;
    logic [S_BW-1:0]   s_blocks;
    logic [15:0]       s_occ;
    logic [S_RW-1:0]   s_regl;
    logic [S_SW-1:0]   s_spadl;

    logic              f_start = 1'b0;
    logic [10:0]       f_thr = '0;
    logic [7:0]        f_rpt = '0;
    logic [14:0]       f_spb = '0;
    logic              f_busy, f_done, f_err;
    logic [F_BW-1:0]   f_blocks;
    logic [15:0]       f_occ;
    logic [F_RW-1:0]   f_regl;
    logic [F_SW-1:0]   f_spadl;

    residency_calc #(
        .REG_CAP(S_REG), .SPAD_CAP(S_SPAD), .BLK_MAX(S_BLK), .THR_MAX(S_THR),
        .TPB_W(S_TPBW), .RPT_W(S_RPTW), .SPB_W(S_SPBW)
    ) uut (
        .clk(clk), .rst(rst), .start_i(s_start),
        .thr_per_blk_i(s_thr), .regs_per_thr_i(s_rpt), .spad_per_blk_i(s_spb),
        .busy_o(s_busy), .done_o(s_done), .err_o(s_err), .blocks_o(s_blocks),
        .occ_o(s_occ), .reg_left_o(s_regl), .spad_left_o(s_spadl)
    );

    residency_calc uut_full (
        .clk(clk), .rst(rst), .start_i(f_start),
        .thr_per_blk_i(f_thr), .regs_per_thr_i(f_rpt), .spad_per_blk_i(f_spb),
        .busy_o(f_busy), .done_o(f_done), .err_o(f_err), .blocks_o(f_blocks),
        .occ_o(f_occ), .reg_left_o(f_regl), .spad_left_o(f_spadl)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model(input int rc, input int sc, input int bm, input int tm,
                                  input int thr, input int rpt, input int spb,
                                  output int blk, output int occ, output int rl,
                                  output int sl, output int er, output string lim);
        int rpb, br, bs, bt;
        if (thr == 0 || rpt == 0) begin
            blk = 0; occ = 0; rl = 0; sl = 0; er = 1; lim = "R8";
            return;
        end
        er  = 0;
        rpb = thr * rpt;
        br  = rc / rpb;
        bs  = (spb == 0) ? bm : sc / spb;
        bt  = tm / thr;
        blk = bm; lim = "R4";
        if (bt < blk) begin blk = bt; lim = "R3"; end
        if (bs < blk) begin blk = bs; lim = "R2"; end
        if (br < blk) begin blk = br; lim = "R1"; end
        occ = (blk * thr * 65536) / tm;
        if (occ > 65535) occ = 65535;
        rl = rc - blk * rpb;
        sl = sc - blk * spb;
    endfunction

    task automatic run_small(input int thr, input int rpt, input int spb);
        int blk, occ, rl, sl, er, g;
        string lim;
        @(negedge clk);
        s_thr = S_TPBW'(thr); s_rpt = S_RPTW'(rpt); s_spb = S_SPBW'(spb);
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        chk("R9 busy after start", int'(s_busy), 1);
        g = 0;
        while (!s_done && g < 400) begin @(negedge clk); g++; end
        model(S_REG, S_SPAD, S_BLK, S_THR, thr, rpt, spb, blk, occ, rl, sl, er, lim);
        chk($sformatf("%s blocks t=%0d r=%0d s=%0d", lim, thr, rpt, spb), int'(s_blocks), blk);
        chk($sformatf("R5 occ t=%0d r=%0d s=%0d", thr, rpt, spb), int'(s_occ), occ);
        chk($sformatf("R6 reg_left t=%0d r=%0d", thr, rpt), int'(s_regl), rl);
        chk($sformatf("R7 spad_left s=%0d", spb), int'(s_spadl), sl);
        chk($sformatf("R8 err t=%0d r=%0d", thr, rpt), int'(s_err), er);
        @(negedge clk);
        chk("R9 done one cycle", int'(s_done), 0);
    endtask

    task automatic run_full(input int thr, input int rpt, input int spb);
        int blk, occ, rl, sl, er, g;
        string lim;
        @(negedge clk);
        f_thr = 11'(thr); f_rpt = 8'(rpt); f_spb = 15'(spb);
        f_start = 1'b1;
        @(negedge clk);
        f_start = 1'b0;
        g = 0;
        while (!f_done && g < 400) begin @(negedge clk); g++; end
        model(F_REG, F_SPAD, F_BLK, F_THR, thr, rpt, spb, blk, occ, rl, sl, er, lim);
        chk($sformatf("%s full blocks t=%0d r=%0d s=%0d", lim, thr, rpt, spb), int'(f_blocks), blk);
        chk("R5 full occ", int'(f_occ), occ);
        chk("R6 full reg_left", int'(f_regl), rl);
        chk("R7 full spad_left", int'(f_spadl), sl);
        chk("R8 full err", int'(f_err), er);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int blk, occ, rl, sl, er, g, pulses;
        string lim;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 busy", int'(s_busy), 0);
        chk("R11 done", int'(s_done), 0);
        chk("R11 err", int'(s_err), 0);
        chk("R11 blocks", int'(s_blocks), 0);
        chk("R11 occ", int'(s_occ), 0);
        chk("R11 reg_left", int'(s_regl), 0);
        chk("R11 spad_left", int'(s_spadl), 0);
        rst = 1'b0;

        // sweep over the small configuration
        for (int t = 0; t < 16; t++)
            for (int r = 0; r < 6; r++)
                for (int s = 0; s < 10; s++)
                    run_small(t, r, s);

        // R1: block needs more registers than exist; R2: spad need above capacity
        run_small(31, 15, 0);
        run_small(4, 2, 100);
        run_small(31, 1, 1);
        // R5: exact full occupancy saturates (12 threads x 4 blocks = 48)
        run_small(12, 1, 0);

        // R10: start while busy is ignored
        @(negedge clk);
        s_thr = 5'd4; s_rpt = 4'd2; s_spb = 7'd3;
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        repeat (5) @(negedge clk);
        s_thr = 5'd15; s_rpt = 4'd5; s_spb = 7'd9;
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        g = 0;
        while (!s_done && g < 400) begin @(negedge clk); g++; end
        model(S_REG, S_SPAD, S_BLK, S_THR, 4, 2, 3, blk, occ, rl, sl, er, lim);
        chk("R10 blocks of first request", int'(s_blocks), blk);
        chk("R10 occ of first request", int'(s_occ), occ);
        chk("R10 spad_left of first request", int'(s_spadl), sl);
        s_start = 1'b1;      // lands in the done cycle: busy, so ignored
        @(negedge clk);
        s_start = 1'b0;
        pulses = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (s_done) pulses++;
        end
        chk("R10 no extra done pulses", pulses, 0);
        chk("R10 busy idle", int'(s_busy), 0);

        // full-size instance
        run_full(256, 36, 0);
        run_full(256, 36, 7200);
        run_full(64, 8, 7200);
        run_full(192, 16, 0);
        run_full(0, 36, 100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule